// File: doc/BRIEF.md
# Segment Base and Limit Translator

This block turns an offset within a segment into a linear address. It holds six segment entries. Each entry stores a 32-bit starting base, a 16-bit limit and a granularity flag. The flag chooses whether the limit counts single bytes or 4096-byte blocks. A lookup names one entry through a 3-bit select and supplies a 32-bit offset. The block scales the limit and compares the offset against it. If the offset fits, the block adds the base and returns the sum as the linear address. If the offset does not fit, or the select names no entry, the block signals a fault instead.

A flat-mode input turns segmentation off. In flat mode the offset passes through unchanged and no check is made. The entries are loaded through a write port. Each lookup returns exactly one registered result on the cycle after the request: either an address-valid pulse or a fault pulse.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_fault` are low. Every entry holds base 0, limit 0 and byte granularity, so offset 0 is accepted and offset 1 faults on every select from 0 to 5.
- R2: A request sampled at a rising edge produces its result at the outputs directly after that edge, for one cycle. A cycle with no request produces neither `rsp_valid` nor `rsp_fault`.
- R3: An accepted lookup returns `rsp_valid`=1 and `rsp_addr` = base + offset modulo 2^32.
- R4: With `gran`=0, the effective limit equals the 16-bit limit. An offset equal to the limit is accepted, and limit+1 faults.
- R5: With `gran`=1, the effective limit is limit*4096 + 4095. An offset equal to that value is accepted, and one more faults.
- R6: A faulting lookup gives `rsp_fault`=1, `rsp_valid`=0 and `rsp_addr`=0.
- R7: In segmented mode, a select of 6 or 7 always faults.
- R8: With `flat_mode`=1, `rsp_valid`=1 and `rsp_addr` equals the offset, whatever the select or the stored limits.
- R9: A write with `wr_sel` from 0 to 5 loads base, limit and granularity into that entry. A write with `wr_sel` of 6 or 7 changes no entry.
- R10: A lookup in the same cycle as a write to its entry uses the old contents. The next lookup uses the new contents.
- R11: `rsp_valid` and `rsp_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Load an entry this cycle |
| wr_sel | input | 3 | Entry to load |
| wr_base | input | 32 | Base to load |
| wr_limit | input | 16 | Limit to load |
| wr_gran | input | 1 | Granularity to load (1 = 4096-byte units) |
| req_valid | input | 1 | Lookup request |
| req_sel | input | 3 | Entry used by the lookup |
| req_offset | input | 32 | Offset within the segment |
| flat_mode | input | 1 | Bypass segmentation |
| rsp_valid | output | 1 | Address-valid pulse |
| rsp_fault | output | 1 | Fault pulse |
| rsp_addr | output | 32 | Linear address, zero on a fault |

## Verification
A corrupted entry becomes visible on the first lookup through that select. It shows as a wrong `rsp_addr`, or as a fault on an offset that should pass, or the reverse, one cycle after the request. The bench therefore probes every entry just below, at and just above its scaled limit, and near the top of the offset range. A wrong limit scaling or a write landing in the wrong entry gives a mismatch within that same single-cycle response. A lost or misplaced output register shows up as a pulse in the wrong cycle, or as a pulse that does not come.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int ADDR_W = 32;
    localparam int LIM_W  = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
    } seg_entry_t;

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [ADDR_W-1:0] addr;
    } xlate_rsp_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  seg_entry_t       wr_ent,
    input  logic [SEL_W-1:0] rd_sel,
    output seg_entry_t       rd_ent,
    output logic             rd_ok
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_SEG - 1);

    seg_entry_t [NUM_SEG-1:0] ents_d, ents_q;
    logic       [NUM_SEG-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEG; gi++) begin : g_hit
            assign hit[gi] = wr_en && (wr_sel == SEL_W'(gi));
        end
    endgenerate

    always_comb begin
        ents_d = ents_q;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (hit[i]) ents_d[i] = wr_ent;
        end
        rd_ok  = (rd_sel <= LAST_SEL);
        rd_ent = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_sel == SEL_W'(i)) rd_ent = ents_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ents_q <= '0;
        else        ents_q <= ents_d;
    end

    AST_WR_OUT_OF_RANGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > LAST_SEL) |=> (ents_q == $past(ents_q))); // R9
    AST_WR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> (ents_q == $past(ents_q))); // R9
    AST_ONE_HIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R9
endmodule

// File: rtl/seg_bound_chk.sv
module seg_bound_chk #(
    parameter int ADDR_W     = 32,
    parameter int LIM_W      = 16,
    parameter int GRAN_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic              gran,
    input  logic [ADDR_W-1:0] offset,
    output logic              over,
    output logic [ADDR_W-1:0] lin_addr
);
    localparam int PAD_BYTE  = ADDR_W - LIM_W;
    localparam int PAD_BLOCK = ADDR_W - LIM_W - GRAN_SHIFT;

    logic [ADDR_W-1:0] eff_limit;

    generate
        if (PAD_BLOCK > 0) begin : g_pad
            always_comb begin
                if (gran) eff_limit = {{PAD_BLOCK{1'b0}}, limit, {GRAN_SHIFT{1'b1}}};
                else      eff_limit = {{PAD_BYTE{1'b0}}, limit};
            end
        end else begin : g_nopad
            always_comb begin
                if (gran) eff_limit = {limit, {GRAN_SHIFT{1'b1}}};
                else      eff_limit = {{PAD_BYTE{1'b0}}, limit};
            end
        end
    endgenerate

    always_comb begin
        over     = (offset > eff_limit);
        lin_addr = base + offset;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG    = 6,
    parameter int SEL_W      = 3,
    parameter int GRAN_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_gran,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic              flat_mode,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_SEG - 1);

    seg_entry_t        wr_ent, rd_ent;
    logic              rd_ok, over;
    logic [ADDR_W-1:0] sum;
    xlate_rsp_t        rsp_d, rsp_q;

    assign wr_ent = '{base: wr_base, limit: wr_limit, gran: wr_gran};

    seg_regfile #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_ent (wr_ent),
        .rd_sel (req_sel),
        .rd_ent (rd_ent),
        .rd_ok  (rd_ok)
    );

    seg_bound_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT)) u_chk (
        .base     (rd_ent.base),
        .limit    (rd_ent.limit),
        .gran     (rd_ent.gran),
        .offset   (req_offset),
        .over     (over),
        .lin_addr (sum)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            if (flat_mode) begin
                rsp_d.valid = 1'b1;
                rsp_d.addr  = req_offset;
            end else if (!rd_ok || over) begin
                rsp_d.fault = 1'b1;
            end else begin
                rsp_d.valid = 1'b1;
                rsp_d.addr  = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_addr  = rsp_q.addr;

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault)); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |=> (!rsp_valid && !rsp_fault)); // R2
    AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_addr == '0)); // R6
    AST_BAD_SEL_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flat_mode && req_sel > LAST_SEL) |=> rsp_fault); // R7
    AST_FLAT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flat_mode) |=> (rsp_valid && rsp_addr == $past(req_offset))); // R8
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_base = '0;
    logic [15:0] wr_limit = '0;
    logic        wr_gran = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [31:0] req_offset = '0;
    logic        flat_mode = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_base [6];
    logic [15:0] m_lim  [6];
    logic        m_gran [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_gran(wr_gran),
        .req_valid(req_valid), .req_sel(req_sel), .req_offset(req_offset),
        .flat_mode(flat_mode), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_addr(rsp_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] eff_of(input int s);
        if (m_gran[s]) return ({16'h0, m_lim[s]} << 12) + 32'hFFF;
        return {16'h0, m_lim[s]};
    endfunction

    // drive at a falling edge, result is registered at the following rising edge
    task automatic lookup(input string req, input logic [2:0] sel, input logic [31:0] off,
                          input logic flat);
        logic        e_fault;
        logic [31:0] e_addr;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_offset = off; flat_mode = flat;
        if (flat) begin
            e_fault = 1'b0; e_addr = off;
        end else if (sel > 3'd5) begin
            e_fault = 1'b1; e_addr = '0;
        end else if (off > eff_of(int'(sel))) begin
            e_fault = 1'b1; e_addr = '0;
        end else begin
            e_fault = 1'b0; e_addr = m_base[sel] + off;
        end
        @(negedge clk);
        req_valid = 1'b0; flat_mode = 1'b0;
        check({req, " valid"}, {31'h0, rsp_valid}, {31'h0, !e_fault});
        check({req, " fault"}, {31'h0, rsp_fault}, {31'h0, e_fault});
        check({req, " addr"},  rsp_addr, e_addr);
    endtask

    task automatic load(input logic [2:0] sel, input logic [31:0] b, input logic [15:0] l,
                        input logic g);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_base = b; wr_limit = l; wr_gran = g;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel <= 3'd5) begin
            m_base[sel] = b; m_lim[sel] = l; m_gran[sel] = g;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_gran[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs and of every entry
        check("R1 reset valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 reset fault", {31'h0, rsp_fault}, 32'h0);
        for (int s = 0; s < 6; s++) begin
            lookup("R1 reset offset0", 3'(s), 32'h0, 1'b0);
            lookup("R1 reset offset1", 3'(s), 32'h1, 1'b0);
        end

        // R9: load each entry, R4/R5 chosen by granularity
        load(3'd0, 32'h0000_4000, 16'h0000, 1'b0);
        load(3'd1, 32'h1234_5678, 16'hFFFF, 1'b0);
        load(3'd2, 32'h8000_0000, 16'h1234, 1'b1);
        load(3'd3, 32'h0000_1000, 16'hFFFF, 1'b1);
        load(3'd4, 32'hFFFF_FF00, 16'h00FF, 1'b0);
        load(3'd5, 32'hFFFF_F000, 16'h0003, 1'b1);

        // R3 R4 R5 R6: sweep around each scaled limit
        for (int s = 0; s < 6; s++) begin
            logic [31:0] e;
            e = eff_of(s);
            lookup("R3 zero", 3'(s), 32'h0, 1'b0);
            lookup("R3 one", 3'(s), 32'h1, 1'b0);
            lookup(m_gran[s] ? "R5 below" : "R4 below", 3'(s), e - 32'h1, 1'b0);
            lookup(m_gran[s] ? "R5 at" : "R4 at", 3'(s), e, 1'b0);
            lookup(m_gran[s] ? "R5 above" : "R4 above", 3'(s), e + 32'h1, 1'b0);
            lookup("R6 high", 3'(s), 32'h8000_0000, 1'b0);
            lookup("R6 max", 3'(s), 32'hFFFF_FFFF, 1'b0);
        end
        // R3: wrap-around modulo 2^32
        lookup("R3 wrap", 3'd5, 32'h0000_2000, 1'b0);
        lookup("R3 wrap byte", 3'd4, 32'h0000_00FF, 1'b0);

        // R7: selects 6 and 7
        lookup("R7 sel6", 3'd6, 32'h0, 1'b0);
        lookup("R7 sel7", 3'd7, 32'h0, 1'b0);

        // R8: flat mode ignores selects and limits
        lookup("R8 flat sel0", 3'd0, 32'hDEAD_BEEF, 1'b1);
        lookup("R8 flat sel7", 3'd7, 32'hFFFF_FFFF, 1'b1);
        lookup("R8 flat sel4", 3'd4, 32'h0000_0123, 1'b1);

        // R9: writes to 6 and 7 leave every entry unchanged
        load(3'd6, 32'hAAAA_AAAA, 16'h0000, 1'b0);
        load(3'd7, 32'h5555_5555, 16'h0000, 1'b1);
        for (int s = 0; s < 6; s++) begin
            lookup("R9 ignored write at", 3'(s), eff_of(s), 1'b0);
            lookup("R9 ignored write above", 3'(s), eff_of(s) + 32'h1, 1'b0);
        end

        // R10: write and lookup in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd2; wr_base = 32'h0000_0100; wr_limit = 16'h0010; wr_gran = 1'b0;
        req_valid = 1'b1; req_sel = 3'd2; req_offset = 32'h0000_0020; flat_mode = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R10 old contents valid", {31'h0, rsp_valid}, 32'h1);
        check("R10 old contents addr", rsp_addr, 32'h8000_0020);
        m_base[2] = 32'h0000_0100; m_lim[2] = 16'h0010; m_gran[2] = 1'b0;
        lookup("R10 new contents fault", 3'd2, 32'h0000_0020, 1'b0);
        lookup("R10 new contents addr", 3'd2, 32'h0000_0010, 1'b0);

        // R2 R11: idle cycle gives no pulse
        @(negedge clk);
        check("R2 idle valid", {31'h0, rsp_valid}, 32'h0);
        check("R11 idle fault", {31'h0, rsp_fault}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule